// File: doc/BRIEF.md
# Scrolling Line-Buffer Address Sequencer

This block produces read addresses for a memory that holds one circular line of samples for a raster display that scrolls sideways. There is one address register, and it never reloads. It moves forward one location on each pulse of a sample-rate enable, but only while a phase sequencer lets it.

During the visible part of a line the sequencer allows a fixed number of steps. Blanking has two phases of its own:

- The rewind phase takes enough further steps to bring the address all the way round the ring to where the line began.
- The shift phase adds a few more steps.

Every line therefore starts a small fixed distance further round the ring than the line before it, and the picture drifts from right to left.

Beside the address, the block gives:

- an enable that says when the address bus should be driven;
- a strobe one clock after each visible-line step;
- a register that captures the memory's read data on that strobe and holds it for the converter that follows;
- a one-clock pulse marking each new line.

After the shift phase the sequencer waits in an idle state until the line-start input arrives.

Top module: `scroll_addr_seq`

## Requirements
- R1: When reset is high at a clock edge, the next cycle shows addr_o = 0, addr_oe_o = 1 (visible phase), line_start_o = 0, pix_stb_o = 0 and pix_o = 0.
- R2: The address moves forward by exactly one location on each clock where tick_i is high and the sequencer is in the visible, rewind or shift phase. At every other clock, including ticks during the idle wait, the address holds its value.
- R3: The visible phase lasts exactly ACT_TICKS ticks. addr_oe_o is high during the visible phase and low in every other phase.
- R4: After the rewind phase's REWIND_TICKS ticks, the address equals the start address of the line just displayed.
- R5: The shift phase follows with exactly SHIFT_TICKS ticks and leaves the address at the line start plus SHIFT_TICKS. The sequencer then enters the idle wait.
- R6: The address counts modulo RING = ACT_TICKS + REWIND_TICKS. From RING-1 it steps to 0.
- R7: In the idle wait, a high line_go_i moves the sequencer to the visible phase. line_start_o is high for exactly the first clock of that phase. line_go_i has no effect in any other phase.
- R8: Each line starts SHIFT_TICKS locations (modulo RING) later than the line before it. The first line after reset starts at 0.
- R9: pix_stb_o goes high for one clock, one cycle after each visible-phase tick. This gives exactly ACT_TICKS strobes per line.
- R10: pix_o takes the value rd_data_i had during a strobe cycle and holds it unchanged until the next strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Sample-rate enable, one clock wide per sample |
| line_go_i | input | 1 | Start of the next visible line (used only in the idle wait) |
| rd_data_i | input | DATA_W | Read data returned by the line memory |
| addr_o | output | ADDR_W | Line memory read address |
| addr_oe_o | output | 1 | Address bus drive enable, high in the visible phase |
| line_start_o | output | 1 | One-clock pulse on the first cycle of each visible phase |
| pix_stb_o | output | 1 | Pixel capture strobe |
| pix_o | output | DATA_W | Captured pixel value |

## Verification
The bench runs the block with small phase counts so the ring wraps within a few lines. This exposes a counter that overruns RING-1 or that loses the shift offset at the wrap, either of which would make line starts stop following the +SHIFT_TICKS pattern. Each phase boundary is checked step by step. An off-by-one phase length would give a rewind that misses the line start, or an address enable that drops a tick early or late. Ticks during the idle wait and a line_go_i pulse in the middle of a line are both applied, to catch a sequencer that drifts while idle or restarts a line it should ignore. The capture register is compared against the data seen in each strobe cycle and must hold between strobes, so a latch that follows its input or that samples one cycle off would be caught. Slow tick spacing is also used, to show that the address moves only on ticks.

// File: rtl/scroll_seq_pkg.sv
package scroll_seq_pkg;
  typedef enum logic [1:0] {
    PH_ACTIVE = 2'd0,
    PH_REWIND = 2'd1,
    PH_SHIFT  = 2'd2,
    PH_IDLE   = 2'd3
  } phase_e;
endpackage

// File: rtl/scroll_phase_seq.sv
module scroll_phase_seq
  import scroll_seq_pkg::*;
#(
  parameter int ACT_TICKS    = 1400,
  parameter int REWIND_TICKS = 400,
  parameter int SHIFT_TICKS  = 8
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   tick_i,
  input  logic   line_go_i,
  output phase_e phase_o,
  output logic   adv_o,
  output logic   line_start_o,
  output logic   stb_o
);
  localparam int MAX_A = (ACT_TICKS >= REWIND_TICKS) ? ACT_TICKS : REWIND_TICKS;
  localparam int MAXC  = (MAX_A >= SHIFT_TICKS) ? MAX_A : SHIFT_TICKS;
  localparam int CW    = $clog2(MAXC + 1);
  localparam logic [CW-1:0] ACT_LAST = CW'(ACT_TICKS - 1);
  localparam logic [CW-1:0] REW_LAST = CW'(REWIND_TICKS - 1);
  localparam logic [CW-1:0] SH_LAST  = CW'(SHIFT_TICKS - 1);

  phase_e        phase_q, phase_nx;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_cnt;

  // Final count and successor of each counting phase
  always_comb begin
    unique case (phase_q)
      PH_ACTIVE: begin last_cnt = ACT_LAST; phase_nx = PH_REWIND; end
      PH_REWIND: begin last_cnt = REW_LAST; phase_nx = PH_SHIFT;  end
      PH_SHIFT:  begin last_cnt = SH_LAST;  phase_nx = PH_IDLE;   end
      default:   begin last_cnt = '0;       phase_nx = PH_IDLE;   end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q      <= PH_ACTIVE;
      cnt_q        <= '0;
      line_start_o <= 1'b0;
      stb_o        <= 1'b0;
    end else begin
      line_start_o <= 1'b0;
      stb_o        <= tick_i && (phase_q == PH_ACTIVE);
      if (phase_q == PH_IDLE) begin
        if (line_go_i) begin
          phase_q      <= PH_ACTIVE;
          cnt_q        <= '0;
          line_start_o <= 1'b1;
        end
      end else if (tick_i) begin
        if (cnt_q == last_cnt) begin
          cnt_q   <= '0;
          phase_q <= phase_nx;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign phase_o = phase_q;
  assign adv_o   = tick_i && (phase_q != PH_IDLE);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (phase_q != PH_IDLE) |-> (cnt_q <= last_cnt)); // R3
  AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE) |-> (cnt_q == '0)); // R5
  AST_LS_FIRST_CYCLE: assert property (@(posedge clk) disable iff (rst)
    line_start_o |-> (phase_q == PH_ACTIVE && cnt_q == '0)); // R7
  AST_STB_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    stb_o |-> $past(tick_i)); // R9
endmodule

// File: rtl/scroll_ring_ctr.sv
module scroll_ring_ctr #(
  parameter int RING   = 1800,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] TOP = ADDR_W'(RING - 1);

  always_ff @(posedge clk) begin
    if (rst)        addr_o <= '0;
    else if (adv_i) addr_o <= (addr_o == TOP) ? '0 : addr_o + 1'b1;
  end

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
    addr_o <= TOP); // R6
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (adv_i && addr_o != TOP) |=> (addr_o == $past(addr_o) + 1'b1)); // R2
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (adv_i && addr_o == TOP) |=> (addr_o == '0)); // R6
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> $stable(addr_o)); // R2
endmodule

// File: rtl/scroll_pix_latch.sv
module scroll_pix_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst)        q_o <= '0;
    else if (stb_i) q_o <= d_i;
  end

  AST_PIX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !stb_i |=> $stable(q_o)); // R10
  AST_PIX_LOAD: assert property (@(posedge clk) disable iff (rst)
    stb_i |=> (q_o == $past(d_i))); // R10
endmodule

// File: rtl/scroll_addr_seq.sv
module scroll_addr_seq
  import scroll_seq_pkg::*;
#(
  parameter int ACT_TICKS    = 1400,
  parameter int REWIND_TICKS = 400,
  parameter int SHIFT_TICKS  = 8,
  parameter int DATA_W       = 8,
  localparam int RING        = ACT_TICKS + REWIND_TICKS,
  localparam int ADDR_W      = $clog2(RING)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              line_go_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_oe_o,
  output logic              line_start_o,
  output logic              pix_stb_o,
  output logic [DATA_W-1:0] pix_o
);
  phase_e phase;
  logic   adv;

  scroll_phase_seq #(
    .ACT_TICKS   (ACT_TICKS),
    .REWIND_TICKS(REWIND_TICKS),
    .SHIFT_TICKS (SHIFT_TICKS)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick_i),
    .line_go_i   (line_go_i),
    .phase_o     (phase),
    .adv_o       (adv),
    .line_start_o(line_start_o),
    .stb_o       (pix_stb_o)
  );

  scroll_ring_ctr #(
    .RING  (RING),
    .ADDR_W(ADDR_W)
  ) u_ctr (
    .clk   (clk),
    .rst   (rst),
    .adv_i (adv),
    .addr_o(addr_o)
  );

  scroll_pix_latch #(
    .DATA_W(DATA_W)
  ) u_pix (
    .clk  (clk),
    .rst  (rst),
    .stb_i(pix_stb_o),
    .d_i  (rd_data_i),
    .q_o  (pix_o)
  );

  assign addr_oe_o = (phase == PH_ACTIVE);

  AST_LS_DRIVES_BUS: assert property (@(posedge clk) disable iff (rst)
    line_start_o |-> (addr_oe_o && !$past(addr_oe_o))); // R7
  AST_IDLE_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE) |=> $stable(addr_o)); // R2
endmodule

// File: tb/scroll_addr_seq_tb.sv
`timescale 1ns/1ps
module scroll_addr_seq_tb;
  localparam int ACT  = 20;
  localparam int REW  = 7;
  localparam int SH   = 4;
  localparam int RING = ACT + REW;
  localparam int AW   = $clog2(RING);
  localparam int DW   = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick_i = 1'b0;
  logic          line_go_i = 1'b0;
  logic [DW-1:0] rd_data_i;
  logic [AW-1:0] addr_o;
  logic          addr_oe_o, line_start_o, pix_stb_o;
  logic [DW-1:0] pix_o;

  int checks = 0;
  int fails = 0;
  int stb_cnt = 0;
  int exp_start = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  // Memory model: data depends on the address
  assign rd_data_i = DW'(addr_o) ^ 8'hA5;

  scroll_addr_seq #(
    .ACT_TICKS(ACT), .REWIND_TICKS(REW), .SHIFT_TICKS(SH), .DATA_W(DW)
  ) u_dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .line_go_i(line_go_i),
    .rd_data_i(rd_data_i), .addr_o(addr_o), .addr_oe_o(addr_oe_o),
    .line_start_o(line_start_o), .pix_stb_o(pix_stb_o), .pix_o(pix_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) if (!rst && pix_stb_o) stb_cnt++;

  // R10 monitor: capture on strobe, hold otherwise
  logic          prev_stb;
  logic [DW-1:0] prev_rd, prev_pix;
  always @(negedge clk) begin
    if (mon_en) begin
      if (prev_stb) chk(pix_o == prev_rd, "R10 capture", pix_o, prev_rd);
      else          chk(pix_o == prev_pix, "R10 hold", pix_o, prev_pix);
    end
    prev_stb = pix_stb_o;
    prev_rd  = rd_data_i;
    prev_pix = pix_o;
  end

  task automatic tick_once(input int gap);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(addr_o == 0, "R1 addr", addr_o, 0);
    chk(addr_oe_o == 1'b1, "R1 oe", addr_oe_o, 1);
    chk(line_start_o == 1'b0, "R1 line_start", line_start_o, 0);
    chk(pix_stb_o == 1'b0, "R1 strobe", pix_stb_o, 0);
    chk(pix_o == 0, "R1 pix", pix_o, 0);
    @(negedge clk);
    chk(addr_o == 0, "R2 no tick hold", addr_o, 0);
  endtask

  task automatic t_line(input int gap, input bit mid_go);
    int s = exp_start;
    stb_cnt = 0;
    chk(int'(addr_o) == s, "R8 line start addr", addr_o, s);
    chk(addr_oe_o == 1'b1, "R3 oe in visible", addr_oe_o, 1);
    for (int k = 1; k <= ACT; k++) begin
      if (mid_go && k == ACT / 2) begin
        line_go_i = 1'b1;
        @(negedge clk);
        line_go_i = 1'b0;
        chk(line_start_o == 1'b0, "R7 go ignored pulse", line_start_o, 0);
        chk(int'(addr_o) == (s + k - 1) % RING, "R7 go ignored addr", addr_o, (s + k - 1) % RING);
      end
      tick_once(gap);
      chk(int'(addr_o) == (s + k) % RING, "R2 step", addr_o, (s + k) % RING);
      chk(addr_oe_o == (k < ACT), "R3 oe span", addr_oe_o, int'(k < ACT));
    end
    for (int k = 1; k <= REW; k++) begin
      tick_once(gap);
      chk(int'(addr_o) == (s + ACT + k) % RING, "R6 ring step", addr_o, (s + ACT + k) % RING);
      chk(addr_oe_o == 1'b0, "R3 oe low rewind", addr_oe_o, 0);
    end
    chk(int'(addr_o) == s, "R4 rewind to start", addr_o, s);
    for (int k = 1; k <= SH; k++) tick_once(gap);
    chk(int'(addr_o) == (s + SH) % RING, "R5 shift end", addr_o, (s + SH) % RING);
    for (int k = 0; k < 3; k++) tick_once(0);
    chk(int'(addr_o) == (s + SH) % RING, "R2 idle ticks ignored", addr_o, (s + SH) % RING);
    chk(addr_oe_o == 1'b0, "R5 idle oe", addr_oe_o, 0);
    chk(line_start_o == 1'b0, "R7 no pulse in idle", line_start_o, 0);
    chk(stb_cnt == ACT, "R9 strobes per line", stb_cnt, ACT);
    line_go_i = 1'b1;
    @(negedge clk);
    line_go_i = 1'b0;
    chk(line_start_o == 1'b1, "R7 line_start pulse", line_start_o, 1);
    chk(addr_oe_o == 1'b1, "R7 visible entered", addr_oe_o, 1);
    @(negedge clk);
    chk(line_start_o == 1'b0, "R7 pulse one clock", line_start_o, 0);
    exp_start = (s + SH) % RING;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R3 watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    mon_en = 1'b1;
    t_line(0, 1'b0);
    t_line(2, 1'b0);
    t_line(0, 1'b1);
    for (int n = 0; n < 7; n++) t_line(n % 2, 1'b0);
    chk(exp_start == (10 * SH) % RING, "R8 wrapped start", exp_start, (10 * SH) % RING);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule